// File: doc/BRIEF.md
# Dual-Edge Synchronous Buck PWM Generator

This block produces the two gate-drive signals for a synchronous buck power stage: a high-side drive and a complementary low-side drive. The switching frequency is fixed by a programmed period. Inside each period, a center-aligned up/down counter sweeps from its minimum to its maximum and back again. The high-side pulse is placed around the counter maximum. Both drives are interlocked by a programmed dead time, so the two switches are never on together.

The duty command is sampled twice per period. The value present when the counter starts at its minimum sets how early the high-side pulse begins. The value present when the counter reaches its maximum sets how late the pulse ends. A control loop that recomputes its output several times per period can therefore move both edges of the on-pulse within one period. The switching frequency does not change. Two one-cycle trigger pulses, one at the counter minimum and one at the counter maximum, tell the loop's converter when to sample.

The sequencer has three named states. IDLE is entered on reset or while disabled, and both drives are held low. RISE is the counting-up half. FALL is the counting-down half. The transitions are as follows:
- IDLE to RISE on enable: start-of-period latch.
- RISE to FALL when the count reaches half the period less one: mid-period latch.
- FALL to RISE when the count reaches one: next start-of-period latch.
- Any state to IDLE when enable is low.

Top module: `pwm_dual_edge_buck`

## Requirements
- R1: With P the effective period, h = P/2, and A and B the clamped duties latched at the start and at mid-period, the high-side drive is high exactly at period positions h-floor(A/2) through h+ceil(B/2)-1. Position 0 is the cycle in which the start trigger is high, and the high side is never high there.
- R2: The high-side and low-side drives are never high together. The low side is high at positions below h-floor(A/2)-D and at positions from h+ceil(B/2)+D upward, where D is the effective dead time. A dead-time input of 0 is treated as 1.
- R3: The duty command is clamped to the range 0 to max(0, P-2D) before use. A clamped duty of 0 keeps the high side low for the whole period.
- R4: The period input is sampled only at period start. Its least significant bit is ignored, and values below 4 become 4. Consecutive start triggers are exactly P cycles apart.
- R5: The command that takes effect at a latch point is the duty input in that cycle if its valid strobe is high, and otherwise the last accepted value. The start latch and the mid-period latch are independent, so the leading and trailing halves of one pulse can come from different commands.
- R6: While reset is high, or from the clock edge at which enable is sampled low, all four outputs are low.
- R7: The start trigger and the mid trigger are one-cycle pulses at the counter minimum (position 0) and the counter maximum (position h). They are never high together.
- R8: All outputs are registered. After enable is sampled high in IDLE, the start trigger appears at the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces IDLE and both drives low |
| period_i | input | PW | Switching period in clocks (LSB ignored, minimum 4) |
| dead_i | input | DW | Dead-time count in clocks (0 treated as 1) |
| duty_i | input | PW | Duty command in clocks of high-side on time |
| duty_vld_i | input | 1 | Strobe accepting duty_i |
| hs_o | output | 1 | High-side gate drive |
| ls_o | output | 1 | Low-side gate drive |
| trig_lo_o | output | 1 | One-cycle pulse at counter minimum (period start) |
| trig_hi_o | output | 1 | One-cycle pulse at counter maximum (mid-period) |

## Verification
The hardest case to reach from the ports is a period whose leading half comes from one command and whose trailing half comes from another. The only way to reach it is to change the command after the start latch and before the mid latch. Directed steps hold a command for a whole period, then replace it as soon as the start trigger appears, and count the high-side cycles in that period. Long random runs then change the command, the period, the dead time and the enable at arbitrary positions in the period, including in the exact latch cycles. Every output is compared each cycle against a position-based model of the bench.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/pwm_duty_clamp.sv
// Limits a duty command to 0 .. max(0, period - 2*dead)  (R3)
module pwm_duty_clamp #(
    parameter int PW = 12,
    parameter int DW = 6
) (
    input  logic [PW-1:0] per_i,
    input  logic [DW-1:0] dead_i,
    input  logic [PW-1:0] cmd_i,
    output logic [PW-1:0] duty_o
);
    localparam int SW = PW + DW + 1;

    logic [SW-1:0] twice_dead;
    logic [SW-1:0] per_w;
    logic [SW-1:0] limit;

    always_comb begin
        twice_dead = SW'(dead_i) << 1;
        per_w      = SW'(per_i);
        limit      = (per_w > twice_dead) ? (per_w - twice_dead) : '0;
        duty_o     = (SW'(cmd_i) > limit) ? PW'(limit) : cmd_i;
    end
endmodule

// File: rtl/pwm_seq.sv
// Center-aligned counter state machine with start and mid latch points.
module pwm_seq
    import pwm_pkg::*;
#(
    parameter int PW = 12,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [PW-1:0] period_i,
    input  logic [DW-1:0] dead_i,
    input  logic [PW-1:0] duty_i,
    input  logic          duty_vld_i,
    output pwm_state_e    st_o,
    output logic [PW-1:0] cnt_o,
    output logic [PW-1:0] half_o,
    output logic [DW-1:0] dead_o,
    output logic [PW-1:0] lead_o,
    output logic [PW-1:0] trail_o
);
    localparam logic [PW-1:0] MIN_PER = PW'(4);
    localparam logic [PW-1:0] ONE     = PW'(1);

    pwm_state_e    st_q, st_n;
    logic [PW-1:0] cnt_q, cnt_n;
    logic [PW-1:0] half_q, lead_q, trail_q, cmd_q;
    logic [DW-1:0] dead_q;
    logic          at_start, at_mid;

    logic [PW-1:0] cmd_eff, per_even, per_eff, per_cur;
    logic [DW-1:0] dead_eff;
    logic [PW-1:0] duty_start, duty_mid;

    // R5: strobed value wins in its own cycle, otherwise the held value
    assign cmd_eff  = duty_vld_i ? duty_i : cmd_q;
    // R4: even period, at least four clocks
    assign per_even = period_i & ~ONE;
    assign per_eff  = (per_even < MIN_PER) ? MIN_PER : per_even;
    // R2: dead time never below one clock
    assign dead_eff = (dead_i == '0) ? DW'(1) : dead_i;
    assign per_cur  = half_q << 1;

    pwm_duty_clamp #(.PW(PW), .DW(DW)) u_clamp_start (
        .per_i  (per_eff),
        .dead_i (dead_eff),
        .cmd_i  (cmd_eff),
        .duty_o (duty_start)
    );

    pwm_duty_clamp #(.PW(PW), .DW(DW)) u_clamp_mid (
        .per_i  (per_cur),
        .dead_i (dead_q),
        .cmd_i  (cmd_eff),
        .duty_o (duty_mid)
    );

    // next state and latch strobes
    always_comb begin
        st_n     = st_q;
        cnt_n    = cnt_q;
        at_start = 1'b0;
        at_mid   = 1'b0;
        if (!en) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_n     = ST_RISE;
                    cnt_n    = '0;
                    at_start = 1'b1;
                end
                ST_RISE: begin
                    if (cnt_q == half_q - ONE) begin
                        st_n   = ST_FALL;
                        cnt_n  = half_q;
                        at_mid = 1'b1;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                ST_FALL: begin
                    if (cnt_q == ONE) begin
                        st_n     = ST_RISE;
                        cnt_n    = '0;
                        at_start = 1'b1;
                    end else begin
                        cnt_n = cnt_q - ONE;
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // period, dead time and edge latches
    always_ff @(posedge clk) begin
        if (rst) begin
            half_q  <= MIN_PER >> 1;
            dead_q  <= DW'(1);
            lead_q  <= '0;
            trail_q <= '0;
            cmd_q   <= '0;
        end else begin
            cmd_q <= cmd_eff;
            if (at_start) begin
                half_q <= per_eff >> 1;
                dead_q <= dead_eff;
                lead_q <= duty_start >> 1;
            end
            if (at_mid) begin
                trail_q <= (duty_mid >> 1) + PW'(duty_mid[0]);
            end
        end
    end

    assign st_o    = st_q;
    assign cnt_o   = cnt_q;
    assign half_o  = half_q;
    assign dead_o  = dead_q;
    assign lead_o  = lead_q;
    assign trail_o = trail_q;
endmodule

// File: rtl/pwm_decode.sv
// Edge compare and registered drive/trigger outputs (R1, R2, R7, R8).
module pwm_decode
    import pwm_pkg::*;
#(
    parameter int PW = 12,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  pwm_state_e    st_i,
    input  logic [PW-1:0] cnt_i,
    input  logic [PW-1:0] half_i,
    input  logic [DW-1:0] dead_i,
    input  logic [PW-1:0] lead_i,
    input  logic [PW-1:0] trail_i,
    output logic          hs_o,
    output logic          ls_o,
    output logic          trig_lo_o,
    output logic          trig_hi_o
);
    localparam int SW = PW + DW + 2;

    logic [SW-1:0] cnt_w, half_w, dead_w, lead_w, trail_w;
    logic          hs_c, ls_c, lo_c, hi_c;

    always_comb begin
        cnt_w   = SW'(cnt_i);
        half_w  = SW'(half_i);
        dead_w  = SW'(dead_i);
        lead_w  = SW'(lead_i);
        trail_w = SW'(trail_i);
        hs_c    = 1'b0;
        ls_c    = 1'b0;
        lo_c    = 1'b0;
        hi_c    = 1'b0;
        unique case (st_i)
            ST_RISE: begin
                hs_c = (cnt_w + lead_w) >= half_w;
                ls_c = (cnt_w + lead_w + dead_w) < half_w;
                lo_c = (cnt_i == '0);
            end
            ST_FALL: begin
                hs_c = (cnt_w + trail_w) > half_w;
                ls_c = (cnt_w + trail_w + dead_w) <= half_w;
                hi_c = (cnt_i == half_i);
            end
            default: begin
                hs_c = 1'b0;
                ls_c = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_o      <= 1'b0;
            ls_o      <= 1'b0;
            trig_lo_o <= 1'b0;
            trig_hi_o <= 1'b0;
        end else begin
            hs_o      <= en & hs_c;
            ls_o      <= en & ls_c;
            trig_lo_o <= en & lo_c;
            trig_hi_o <= en & hi_c;
        end
    end
endmodule

// File: rtl/pwm_dual_edge_buck.sv
module pwm_dual_edge_buck
    import pwm_pkg::*;
#(
    parameter int PW = 12,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [PW-1:0] period_i,
    input  logic [DW-1:0] dead_i,
    input  logic [PW-1:0] duty_i,
    input  logic          duty_vld_i,
    output logic          hs_o,
    output logic          ls_o,
    output logic          trig_lo_o,
    output logic          trig_hi_o
);
    pwm_state_e    st;
    logic [PW-1:0] cnt, half, lead, trail;
    logic [DW-1:0] dead;

    pwm_seq #(.PW(PW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .period_i   (period_i),
        .dead_i     (dead_i),
        .duty_i     (duty_i),
        .duty_vld_i (duty_vld_i),
        .st_o       (st),
        .cnt_o      (cnt),
        .half_o     (half),
        .dead_o     (dead),
        .lead_o     (lead),
        .trail_o    (trail)
    );

    pwm_decode #(.PW(PW), .DW(DW)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .st_i      (st),
        .cnt_i     (cnt),
        .half_i    (half),
        .dead_i    (dead),
        .lead_i    (lead),
        .trail_i   (trail),
        .hs_o      (hs_o),
        .ls_o      (ls_o),
        .trig_lo_o (trig_lo_o),
        .trig_hi_o (trig_hi_o)
    );
endmodule

// File: rtl/pwm_dual_edge_buck_chk.sv
module pwm_dual_edge_buck_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic hs_o,
    input logic ls_o,
    input logic trig_lo_o,
    input logic trig_hi_o
);
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        !(hs_o && ls_o));

    p_ls_after_gap_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_o) |-> !$past(hs_o));

    p_hs_after_gap_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_o) |-> !$past(ls_o));

    p_start_hs_low_r1: assert property (@(posedge clk) disable iff (rst)
        trig_lo_o |-> !hs_o);

    p_mid_ls_low_r2: assert property (@(posedge clk) disable iff (rst)
        trig_hi_o |-> !ls_o);

    p_quiet_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (!hs_o && !ls_o && !trig_lo_o && !trig_hi_o));

    p_trig_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trig_lo_o, trig_hi_o}));

    p_lo_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        trig_lo_o |=> !trig_lo_o);

    p_hi_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        trig_hi_o |=> !trig_hi_o);
endmodule

bind pwm_dual_edge_buck pwm_dual_edge_buck_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .hs_o      (hs_o),
    .ls_o      (ls_o),
    .trig_lo_o (trig_lo_o),
    .trig_hi_o (trig_hi_o)
);

// File: tb/sim_pwm_dual_edge_buck.sv
`timescale 1ns/1ps
module sim_pwm_dual_edge_buck;
    localparam int PW = 12;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst, en, vld;
    logic [PW-1:0] per, duty;
    logic [DW-1:0] dt;
    logic          hs, ls, tlo, thi;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dual_edge_buck #(.PW(PW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .en(en), .period_i(per), .dead_i(dt),
        .duty_i(duty), .duty_vld_i(vld), .hs_o(hs), .ls_o(ls),
        .trig_lo_o(tlo), .trig_hi_o(thi)
    );

    // position-based reference model
    int m_act, m_t, m_h, m_dt, m_lead, m_trail, m_cmd;
    logic e_hs, e_ls, e_lo, e_hi;

    function automatic int clampd(int c, int p, int d);
        int lim;
        lim = p - 2 * d;
        if (lim < 0) lim = 0;
        return (c > lim) ? lim : c;
    endfunction

    always @(posedge clk) begin : model
        int eff, pe, de;
        if (rst) begin
            m_act = 0; m_t = 0; m_h = 2; m_dt = 1; m_lead = 0; m_trail = 0; m_cmd = 0;
            e_hs = 0; e_ls = 0; e_lo = 0; e_hi = 0;
        end else begin
            eff  = vld ? int'(duty) : m_cmd;
            e_hs = en && m_act != 0 && (m_t >= m_h - m_lead) && (m_t < m_h + m_trail);
            e_ls = en && m_act != 0 && ((m_t < m_h - m_lead - m_dt) || (m_t >= m_h + m_trail + m_dt));
            e_lo = en && m_act != 0 && m_t == 0;
            e_hi = en && m_act != 0 && m_t == m_h;
            m_cmd = eff;
            if (!en) begin
                m_act = 0;
            end else if (m_act == 0 || m_t == 2 * m_h - 1) begin
                pe = int'(per) & ~1;
                if (pe < 4) pe = 4;
                de = (dt == 0) ? 1 : int'(dt);
                m_act = 1; m_t = 0; m_h = pe / 2; m_dt = de;
                m_lead = clampd(eff, pe, de) / 2;
            end else begin
                m_t = m_t + 1;
                if (m_t == m_h) m_trail = (clampd(eff, 2 * m_h, m_dt) + 1) / 2;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk("R1 high-side drive", int'(hs), int'(e_hs));
        chk("R2 low-side drive", int'(ls), int'(e_ls));
        chk("R7 start trigger", int'(tlo), int'(e_lo));
        chk("R7 mid trigger", int'(thi), int'(e_hi));
    endtask

    // count high-side cycles and length of one period, start trigger to start trigger
    task automatic measure(output int hc, output int len);
        int guard;
        guard = 0;
        while (!tlo && guard < 500) begin step(); guard++; end
        hc = 0; len = 0;
        do begin
            if (hs) hc++;
            len++;
            step();
        end while (!tlo && len < 500);
    endtask

    initial begin : watchdog
        #(5.0 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int hc, len;
        void'($urandom(32'd7331));
        rst = 1; en = 0; vld = 0; per = 20; dt = 2; duty = 0;
        repeat (3) @(negedge clk);
        chk("R6 reset hs", int'(hs), 0);
        chk("R6 reset ls", int'(ls), 0);
        chk("R6 reset triggers", int'(tlo | thi), 0);
        rst = 0;

        // R8: start trigger on the second edge after enable
        en = 1; vld = 1; duty = 0;
        step();
        chk("R8 trigger not yet", int'(tlo), 0);
        step();
        chk("R8 trigger at second edge", int'(tlo), 1);

        // R3: zero duty, R4: period length
        measure(hc, len); measure(hc, len);
        chk("R3 zero duty high count", hc, 0);
        chk("R4 period length 20", len, 20);

        // R3: clamp at P-2D
        duty = 100;
        measure(hc, len); measure(hc, len);
        chk("R3 clamp 20-4", hc, 16);

        // R2: dead time 0 acts as 1
        dt = 0;
        measure(hc, len); measure(hc, len);
        chk("R2 dead zero clamp 18", hc, 18);

        // R4: odd period and minimum period
        per = 21; dt = 1;
        measure(hc, len); measure(hc, len);
        chk("R4 odd period rounds down", len, 20);
        per = 3;
        measure(hc, len); measure(hc, len);
        chk("R4 minimum period", len, 4);
        chk("R3 clamp at minimum period", hc, 2);

        // R5: leading half from one command, trailing from another
        per = 24; dt = 2; duty = 10;
        measure(hc, len); measure(hc, len);
        chk("R5 steady duty 10", hc, 10);
        duty = 3;
        measure(hc, len);
        chk("R5 split 10 then 3", hc, 7);
        measure(hc, len);
        chk("R5 next period 3", hc, 3);
        duty = 11;
        measure(hc, len);
        chk("R5 split 3 then 11", hc, 7);
        // R5: strobe low keeps the held command
        vld = 0; duty = 0;
        measure(hc, len); measure(hc, len);
        chk("R5 held command without strobe", hc, 11);
        vld = 1;

        // R6: disable mid-period
        repeat (5) step();
        en = 0;
        step();
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R6 disabled drives low", int'(hs | ls | tlo | thi), 0);
        end
        en = 1;

        // random mix
        for (int i = 0; i < 6000; i++) begin
            step();
            vld  = ($urandom % 3) == 0;
            duty = PW'($urandom % 40);
            if (($urandom % 150) == 0) per = PW'(2 + $urandom % 36);
            if (($urandom % 200) == 0) dt  = DW'($urandom % 6);
            if (($urandom % 400) == 0) en  = 0;
            else if (!en && ($urandom % 4) == 0) en = 1;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule